// File: doc/BRIEF.md
# Next Instruction Address and Link Unit

This block decides where a 32-bit RISC core fetches next. Each cycle it takes the address of the instruction now executing, a decoded control-flow kind, the 16-bit branch displacement, the 26-bit jump index, the two source register values and the destination register index. From these it returns the following fetch address. For calls it also returns a link request: a write enable, the register index to write and the return address to store there.

The unit is purely combinational and sits between decode and the program counter register. It has three kinds of target. A conditional branch adds a word-scaled displacement to the sequential address. A direct jump keeps the top address bits of the sequential address and replaces the rest with a word index. A register jump takes the first source value as its target, unchanged. The comparisons are equality and inequality between the two sources, and the signed tests of the first source against zero. A conditional branch with link writes the return address only when it is taken.

Top module: `npc_unit`

## Requirements
- R1: The kind input uses this encoding: 0 sequential, 1 equal, 2 not-equal, 3 less-than-zero, 4 greater-or-equal-zero, 5 greater-than-zero, 6 less-or-equal-zero, 7 less-than-zero-with-link, 8 greater-or-equal-zero-with-link, 9 direct jump, 10 direct jump-with-link, 11 register jump, 12 register jump-with-link. Codes 13 to 15 behave as code 0. For code 0, for codes 13 to 15 and for any branch that is not taken, the next address is the current address plus 4, modulo 2^32.
- R2: Code 1 is taken when the two source values are equal. Code 2 is taken when they differ.
- R3: Codes 3 to 8 compare the first source, read as a signed two's-complement value, against zero. The tests are: less than zero (codes 3 and 7), greater than or equal to zero (codes 4 and 8), greater than zero (code 5), and less than or equal to zero (code 6). The second source plays no part in them.
- R4: The target of a taken branch is the current address plus 4, plus the displacement sign-extended and multiplied by 4, modulo 2^32.
- R5: The target of a direct jump (codes 9 and 10) has bits 31:28 taken from the current address plus 4, bits 27:2 equal to the 26-bit index, and bits 1:0 zero.
- R6: The target of a register jump (codes 11 and 12) is the first source value, with every bit unchanged.
- R7: Codes 7 and 8 raise the link enable with link index 31 and link value equal to the current address plus 4, but only when taken. When not taken they raise no link.
- R8: Code 10 links to index 31. Code 12 links to the index on the destination input. Both carry the current address plus 4 as the link value.
- R9: When the link enable is low, the link index and link value are both zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pc_cur | input | 32 | Address of the instruction now executing |
| flow_kind | input | 4 | Decoded control-flow kind (encoding in R1) |
| br_disp | input | 16 | Signed branch displacement in words |
| jmp_index | input | 26 | Word index of a direct jump |
| src_a | input | 32 | First source register value (compare operand and register jump target) |
| src_b | input | 32 | Second source register value (equality operand) |
| dst_idx | input | 5 | Destination index for a register jump-with-link |
| pc_next | output | 32 | Address to fetch next |
| link_we | output | 1 | Link write enable |
| link_idx | output | 5 | Register index written with the return address |
| link_val | output | 32 | Return address |

## Verification
The bench works the sign boundaries of the zero compares: zero itself, the most negative value and the most positive value. A design that used an unsigned compare, or swapped strict and non-strict tests, would branch the wrong way at exactly those points. It also drives branches that are not taken with link, where a design that linked on decode instead of on outcome would corrupt register 31. Other cases cover negative displacements, address wrap, and a direct jump whose sequential address crosses a 256 MB region boundary. There a design that took the region bits from the current address rather than from the sequential one would jump into the wrong region. Register jump targets with nonzero low bits catch a design that aligned or shifted the register value.

// File: rtl/npc_pkg.sv
package npc_pkg;

  typedef enum logic [3:0] {
    FK_SEQ    = 4'd0,
    FK_EQ     = 4'd1,
    FK_NE     = 4'd2,
    FK_LTZ    = 4'd3,
    FK_GEZ    = 4'd4,
    FK_GTZ    = 4'd5,
    FK_LEZ    = 4'd6,
    FK_LTZ_LK = 4'd7,
    FK_GEZ_LK = 4'd8,
    FK_JDIR   = 4'd9,
    FK_JDIR_LK= 4'd10,
    FK_JREG   = 4'd11,
    FK_JREG_LK= 4'd12
  } flow_kind_e;

  function automatic logic is_cond_branch(input flow_kind_e k);
    return (k inside {FK_EQ, FK_NE, FK_LTZ, FK_GEZ, FK_GTZ, FK_LEZ,
                      FK_LTZ_LK, FK_GEZ_LK});
  endfunction

  function automatic logic is_link_branch(input flow_kind_e k);
    return (k == FK_LTZ_LK) || (k == FK_GEZ_LK);
  endfunction

  function automatic logic is_dir_jump(input flow_kind_e k);
    return (k == FK_JDIR) || (k == FK_JDIR_LK);
  endfunction

  function automatic logic is_reg_jump(input flow_kind_e k);
    return (k == FK_JREG) || (k == FK_JREG_LK);
  endfunction

endpackage

// File: rtl/npc_cond.sv
module npc_cond
  import npc_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  flow_kind_e        kind,
  input  logic [XLEN-1:0]   opa,
  input  logic [XLEN-1:0]   opb,
  output logic              taken
);

  function automatic logic sgn_neg(input logic [XLEN-1:0] v);
    return v[XLEN-1];
  endfunction

  function automatic logic all_zero(input logic [XLEN-1:0] v);
    return (v == '0);
  endfunction

  logic neg_a, zero_a, same_ab;

  always_comb begin
    neg_a   = sgn_neg(opa);
    zero_a  = all_zero(opa);
    same_ab = (opa == opb);
  end

  always_comb begin
    unique case (kind)
      FK_EQ:                taken = same_ab;
      FK_NE:                taken = !same_ab;
      FK_LTZ, FK_LTZ_LK:    taken = neg_a;
      FK_GEZ, FK_GEZ_LK:    taken = !neg_a;
      FK_GTZ:               taken = !neg_a && !zero_a;
      FK_LEZ:               taken = neg_a || zero_a;
      default:              taken = 1'b0;
    endcase
  end

  // R3
  always_comb begin
    if (kind == FK_GTZ && taken) begin
      gtz_excl_chk: assert (!opa[XLEN-1] && (opa != '0))
        else $error("greater-than-zero taken on non-positive value");
    end
  end

endmodule

// File: rtl/npc_target.sv
module npc_target #(
  parameter int XLEN   = 32,
  parameter int OFF_W  = 16,
  parameter int JIDX_W = 26
) (
  input  logic [XLEN-1:0]   pc_cur,
  input  logic [OFF_W-1:0]  disp,
  input  logic [JIDX_W-1:0] jidx,
  output logic [XLEN-1:0]   seq_pc,
  output logic [XLEN-1:0]   br_pc,
  output logic [XLEN-1:0]   jd_pc
);

  localparam int INSN_BYTES = 4;
  localparam int ALIGN_W    = 2;
  localparam int REGION_W   = XLEN - JIDX_W - ALIGN_W;
  localparam int SEXT_W     = XLEN - OFF_W - ALIGN_W;

  function automatic logic [XLEN-1:0] step_seq(input logic [XLEN-1:0] pc);
    return pc + XLEN'(INSN_BYTES);
  endfunction

  function automatic logic [XLEN-1:0] word_disp(input logic [OFF_W-1:0] d);
    return {{SEXT_W{d[OFF_W-1]}}, d, {ALIGN_W{1'b0}}};
  endfunction

  function automatic logic [XLEN-1:0] region_join(input logic [XLEN-1:0] s,
                                                  input logic [JIDX_W-1:0] j);
    return {s[XLEN-1 -: REGION_W], j, {ALIGN_W{1'b0}}};
  endfunction

  always_comb begin
    seq_pc = step_seq(pc_cur);
    br_pc  = seq_pc + word_disp(disp);
    jd_pc  = region_join(seq_pc, jidx);
  end

  // R5
  always_comb begin
    jd_align_chk: assert (jd_pc[ALIGN_W-1:0] == '0)
      else $error("direct jump target not word aligned");
  end

endmodule

// File: rtl/npc_link.sv
module npc_link
  import npc_pkg::*;
#(
  parameter int XLEN     = 32,
  parameter int RIDX_W   = 5,
  parameter int LINK_REG = 31
) (
  input  flow_kind_e        kind,
  input  logic              taken,
  input  logic [RIDX_W-1:0] dst_idx,
  input  logic [XLEN-1:0]   seq_pc,
  output logic              we,
  output logic [RIDX_W-1:0] idx,
  output logic [XLEN-1:0]   val
);

  localparam logic [RIDX_W-1:0] RA_IDX = RIDX_W'(LINK_REG);

  logic want_link;

  always_comb begin
    want_link = (is_link_branch(kind) && taken) ||
                (kind == FK_JDIR_LK) || (kind == FK_JREG_LK);
    we  = want_link;
    idx = '0;
    val = '0;
    if (want_link) begin
      idx = (kind == FK_JREG_LK) ? dst_idx : RA_IDX;
      val = seq_pc;
    end
  end

endmodule

// File: rtl/npc_unit.sv
module npc_unit
  import npc_pkg::*;
#(
  parameter int XLEN     = 32,
  parameter int OFF_W    = 16,
  parameter int JIDX_W   = 26,
  parameter int RIDX_W   = 5,
  parameter int KIND_W   = 4,
  parameter int LINK_REG = 31
) (
  input  logic [XLEN-1:0]   pc_cur,
  input  logic [KIND_W-1:0] flow_kind,
  input  logic [OFF_W-1:0]  br_disp,
  input  logic [JIDX_W-1:0] jmp_index,
  input  logic [XLEN-1:0]   src_a,
  input  logic [XLEN-1:0]   src_b,
  input  logic [RIDX_W-1:0] dst_idx,
  output logic [XLEN-1:0]   pc_next,
  output logic              link_we,
  output logic [RIDX_W-1:0] link_idx,
  output logic [XLEN-1:0]   link_val
);

  localparam int REGION_W = XLEN - JIDX_W - 2;

  flow_kind_e      kind;
  logic            br_taken;
  logic [XLEN-1:0] seq_pc, br_pc, jd_pc;
  logic            sel_br, sel_jd, sel_jr;

  assign kind = flow_kind_e'(flow_kind);

  npc_cond #(.XLEN(XLEN)) u_cond (
    .kind (kind),
    .opa  (src_a),
    .opb  (src_b),
    .taken(br_taken)
  );

  npc_target #(.XLEN(XLEN), .OFF_W(OFF_W), .JIDX_W(JIDX_W)) u_tgt (
    .pc_cur(pc_cur),
    .disp  (br_disp),
    .jidx  (jmp_index),
    .seq_pc(seq_pc),
    .br_pc (br_pc),
    .jd_pc (jd_pc)
  );

  npc_link #(.XLEN(XLEN), .RIDX_W(RIDX_W), .LINK_REG(LINK_REG)) u_link (
    .kind   (kind),
    .taken  (br_taken),
    .dst_idx(dst_idx),
    .seq_pc (seq_pc),
    .we     (link_we),
    .idx    (link_idx),
    .val    (link_val)
  );

  always_comb begin
    sel_br = is_cond_branch(kind) && br_taken;
    sel_jd = is_dir_jump(kind);
    sel_jr = is_reg_jump(kind);
    if (sel_jr)      pc_next = src_a;
    else if (sel_jd) pc_next = jd_pc;
    else if (sel_br) pc_next = br_pc;
    else             pc_next = seq_pc;
  end

  // R1
  always_comb begin
    if (!sel_br && !sel_jd && !sel_jr) begin
      seq_default_chk: assert (pc_next == pc_cur + XLEN'(4))
        else $error("fall-through address wrong");
    end
  end

  // R7
  always_comb begin
    if (link_we && is_link_branch(kind)) begin
      link_taken_chk: assert (br_taken)
        else $error("link raised on untaken branch");
    end
  end

  // R8
  always_comb begin
    if (link_we && kind != FK_JREG_LK) begin
      link_ra_chk: assert (link_idx == RIDX_W'(LINK_REG) && link_val == pc_cur + XLEN'(4))
        else $error("link index or value wrong");
    end
  end

  // R9
  always_comb begin
    if (!link_we) begin
      link_quiet_chk: assert (link_idx == '0 && link_val == '0)
        else $error("link fields not zero while idle");
    end
  end

  // R5
  always_comb begin
    if (sel_jd) begin
      jd_region_chk: assert (pc_next[XLEN-1 -: REGION_W] == seq_pc[XLEN-1 -: REGION_W])
        else $error("direct jump left its region");
    end
  end

  // R6
  always_comb begin
    if (sel_jr) begin
      jr_pass_chk: assert (pc_next == src_a)
        else $error("register jump target altered");
    end
  end

endmodule

// File: tb/npc_unit_tb.sv
module npc_unit_tb;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [31:0] pc_cur, src_a, src_b, pc_next, link_val;
  logic [3:0]  flow_kind;
  logic [15:0] br_disp;
  logic [25:0] jmp_index;
  logic [4:0]  dst_idx, link_idx;
  logic        link_we;

  npc_unit u_dut (
    .pc_cur(pc_cur), .flow_kind(flow_kind), .br_disp(br_disp),
    .jmp_index(jmp_index), .src_a(src_a), .src_b(src_b), .dst_idx(dst_idx),
    .pc_next(pc_next), .link_we(link_we), .link_idx(link_idx), .link_val(link_val)
  );

  typedef struct {
    logic [31:0] npc;
    logic        we;
    logic [4:0]  idx;
    logic [31:0] val;
    string       tag;
  } exp_t;

  exp_t sb_q[$];
  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  function automatic exp_t model(input logic [3:0] k, input logic [31:0] pc,
                                 input logic [15:0] d, input logic [25:0] j,
                                 input logic [31:0] a, input logic [31:0] b,
                                 input logic [4:0] rd, input string tag);
    exp_t e;
    longint seqv, tgt;
    bit tk, lk;
    int sa;
    seqv = (longint'(pc) + 4) & 64'hFFFF_FFFF;
    sa = $signed(a);
    tk = 0; lk = 0;
    case (k)
      4'd1: tk = (a == b);
      4'd2: tk = (a != b);
      4'd3, 4'd7: tk = (sa < 0);
      4'd4, 4'd8: tk = (sa >= 0);
      4'd5: tk = (sa > 0);
      4'd6: tk = (sa <= 0);
      default: tk = 0;
    endcase
    if (k == 4'd9 || k == 4'd10)
      e.npc = (seqv[31:0] & 32'hF000_0000) | (32'(j) * 4);
    else if (k == 4'd11 || k == 4'd12)
      e.npc = a;
    else if (tk) begin
      tgt = seqv + longint'($signed(d)) * 4;
      e.npc = tgt[31:0];
    end else
      e.npc = seqv[31:0];
    lk = ((k == 4'd7 || k == 4'd8) && tk) || k == 4'd10 || k == 4'd12;
    e.we  = lk;
    e.idx = lk ? ((k == 4'd12) ? rd : 5'd31) : 5'd0;
    e.val = lk ? seqv[31:0] : 32'd0;
    e.tag = tag;
    return e;
  endfunction

  task automatic drive(input logic [3:0] k, input logic [31:0] pc,
                       input logic [15:0] d, input logic [25:0] j,
                       input logic [31:0] a, input logic [31:0] b,
                       input logic [4:0] rd, input string tag);
    @(posedge clk);
    #1;
    flow_kind = k; pc_cur = pc; br_disp = d; jmp_index = j;
    src_a = a; src_b = b; dst_idx = rd;
    sb_q.push_back(model(k, pc, d, j, a, b, rd, tag));
  endtask

  always @(negedge clk) begin
    if (rst_n && sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      n_chk++;
      if (pc_next !== e.npc || link_we !== e.we || link_idx !== e.idx || link_val !== e.val) begin
        n_bad++;
        $display("FAIL %s: got npc=%h we=%b idx=%0d val=%h, expected npc=%h we=%b idx=%0d val=%h",
                 e.tag, pc_next, link_we, link_idx, link_val, e.npc, e.we, e.idx, e.val);
      end
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: got hang, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    flow_kind = 0; pc_cur = 0; br_disp = 0; jmp_index = 0;
    src_a = 0; src_b = 0; dst_idx = 0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // R1 sequential, idle kind, unused codes, wrap at top of space
    drive(4'd0, 32'h0000_0000, 16'h0000, 26'h0, 0, 0, 5'd0, "R1 idle start");
    drive(4'd0, 32'h0040_1000, 16'h7FFF, 26'h3FF_FFFF, 32'hFFFF_FFFF, 0, 5'd3, "R1 seq ignores fields");
    drive(4'd14, 32'h0040_2000, 16'h0010, 26'h1, 32'h1, 32'h1, 5'd3, "R1 unused code 14");
    drive(4'd15, 32'hFFFF_FFFC, 16'h0010, 26'h1, 0, 0, 5'd7, "R1 wrap code 15");
    // R2 equality
    drive(4'd1, 32'h0000_1000, 16'h0004, 0, 32'h1234, 32'h1234, 0, "R2 eq taken");
    drive(4'd1, 32'h0000_1000, 16'h0004, 0, 32'h1234, 32'h1235, 0, "R2 eq not taken");
    drive(4'd2, 32'h0000_1000, 16'h0004, 0, 32'h8000_0000, 32'h0, 0, "R2 ne taken");
    drive(4'd2, 32'h0000_1000, 16'h0004, 0, 32'h77, 32'h77, 0, "R2 ne not taken");
    // R3 sign boundaries
    for (int i = 0; i < 3; i++) begin
      logic [31:0] v;
      v = (i == 0) ? 32'h0 : (i == 1) ? 32'h8000_0000 : 32'h7FFF_FFFF;
      for (int k = 3; k <= 6; k++)
        drive(4'(k), 32'h0000_2000, 16'h0008, 0, v, ~v, 0, $sformatf("R3 code %0d val %h", k, v));
    end
    // R4 displacements
    drive(4'd1, 32'h0000_2000, 16'hFFFF, 0, 5, 5, 0, "R4 disp -1");
    drive(4'd1, 32'h0000_2000, 16'h8000, 0, 5, 5, 0, "R4 disp most negative");
    drive(4'd1, 32'h0000_0010, 16'hFFF0, 0, 5, 5, 0, "R4 backward wrap");
    drive(4'd1, 32'hFFFF_FFF0, 16'h7FFF, 0, 5, 5, 0, "R4 forward wrap");
    // R5 direct jumps
    drive(4'd9, 32'h0040_0000, 16'h0, 26'd32, 0, 0, 0, "R5 jump index 32");
    drive(4'd9, 32'h0FFF_FFFC, 16'h0, 26'h0000_123, 0, 0, 0, "R5 region from pc+4");
    drive(4'd10, 32'hA000_0100, 16'h0, 26'h3FF_FFFF, 0, 0, 5'd4, "R5 R8 jal top index");
    // R6 register jumps
    drive(4'd11, 32'h0040_0000, 16'h0, 0, 32'hDEAD_BEEF, 32'h1, 5'd9, "R6 reg jump odd target");
    drive(4'd12, 32'h0040_0100, 16'h0, 0, 32'h0000_0003, 0, 5'd17, "R6 R8 jalr to rd 17");
    drive(4'd12, 32'hFFFF_FFFC, 16'h0, 0, 32'h1234_5678, 0, 5'd31, "R8 jalr wrap link");
    // R7 link branches
    drive(4'd7, 32'h0000_3000, 16'h0010, 0, 32'hFFFF_FFFF, 0, 5'd2, "R7 ltz link taken");
    drive(4'd7, 32'h0000_3000, 16'h0010, 0, 32'h0, 0, 5'd2, "R7 ltz link not taken");
    drive(4'd8, 32'h0000_3000, 16'hFFFE, 0, 32'h0, 0, 5'd2, "R7 gez link taken zero");
    drive(4'd8, 32'h0000_3000, 16'h0010, 0, 32'h8000_0000, 0, 5'd2, "R7 R9 gez link not taken");
    // R9 idle after link
    drive(4'd3, 32'h0000_4000, 16'h0010, 0, 32'h5, 0, 5'd31, "R9 plain branch no link");
    drive(4'd0, 32'h0000_4000, 16'h0, 0, 0, 0, 5'd31, "R9 seq no link");
    while (sb_q.size() > 0) @(posedge clk);
    @(posedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

endmodule